// File: doc/BRIEF.md
# Multi-Mode Conversion Result Readout Bank

This block holds the 16-bit results of a six-channel converter core and hands them to a host over a parallel strobed read port. The core delivers results two at a time: one strobe carries the pair for group A, B or C (channel x0 and x1 of that group). The host picks one of three read disciplines per read through a 3-bit code: address one channel directly, walk all six channels in a fixed rotation, or drain a first-in first-out queue that keeps results in the order they were produced.

The read port is sampled on the block clock. A read is active while both `csN` and `rdN` are low. The mode code is captured in the cycle the read becomes active, so whichever strobe falls second takes the sample. A result pair that arrives during a read waits in a small staging buffer and is stored only after the read ends. Byte mode splits each 16-bit word into two reads. A tag option reports which channel a cyclic or queued word came from.

Top module: `sample_readout_bank`

## Requirements
- R1: Codes 0 to 5 on `modeSel` select channels A0, A1, B0, B1, C0, C1 in that order (pair index p holds channels 2p and 2p+1). A read returns the latest stored result of that channel, and `rdTag` stays 0 whatever `tagEn` is.
- R2: Code 6 (cyclic) returns channels in the order A0, A1, B0, B1, C0, C1, then wraps to A0. The rotation advances once per completed word.
- R3: After reset, the first cyclic read returns channel A0.
- R4: Code 7 (queue) returns results oldest first. Within one pair, channel x0 is queued ahead of x1.
- R5: The queue holds 18 entries. A pair stored into a queue with fewer than two free slots discards the oldest entries to make room.
- R6: A pair arriving while a read is active changes neither the queue nor the channel registers until the read has ended. It is then stored in full and in order.
- R7: The mode code is taken when the later of `csN` and `rdN` goes low. Changes to `modeSel` during the read affect neither the returned word nor what happens when the read ends.
- R8: Reset empties the queue, clears all channel results to zero and clears the byte phase.
- R9: With `byteMode` high, the first read of a word returns bits 7:0 and the second returns bits 15:8, each on `rdData[7:0]` with `rdData[15:8]` zero. The rotation advances, or the queue head is removed, only after the second read.
- R10: With `tagEn` high in code 6 or 7, `rdTag` carries the channel code (0 to 5) of the returned word. With `tagEn` low it is 0.
- R11: A queue read while the queue is empty returns 0 with tag 0 and leaves the queue unchanged.
- R12: `rdData` and `rdTag` become valid at the clock edge after the read is first seen active. They hold through the read and return to 0 at the edge after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-cycle strobe: a result pair is present |
| wrPair | input | 2 | Group of the pair: 0=A, 1=B, 2=C (3 is ignored) |
| wrData0 | input | 16 | Result of channel x0 of the group |
| wrData1 | input | 16 | Result of channel x1 of the group |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| modeSel | input | 3 | Channel code (0-5), cyclic (6) or queue (7) |
| byteMode | input | 1 | Split words into two byte reads |
| tagEn | input | 1 | Report channel code in cyclic and queue modes |
| rdData | output | 16 | Returned word or byte |
| rdTag | output | 3 | Channel code of the returned word |

## Verification
The bench goes after the places where the three disciplines share state. A write that lands while the queue is being read is held back: if it were stored at once, the read's end would pop the new A0 and the next queue read would return A1. The queue is overfilled by one pair: a design that drops the newest entries, or only one entry, returns a wrong first value or the wrong number of entries. The mode code is moved both before and during a read: a design that samples it too early or too late returns the wrong channel or pops the queue from a direct read. Byte-mode reads check that the rotation and the queue pop wait for the high byte, so a design that steps every read skips channels.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  localparam int NUM_CH    = 6;
  localparam int NUM_PAIRS = NUM_CH / 2;
  localparam int WORD_W    = 16;
  localparam int HALF_W    = WORD_W / 2;
  localparam int CODE_W    = 3;
  localparam int PAIR_W    = 2;

  localparam logic [CODE_W-1:0] MODE_CYCLE = 3'd6;
  localparam logic [CODE_W-1:0] MODE_FIFO  = 3'd7;

  typedef struct packed {
    logic              readActive;
    logic              readStart;
    logic              readEnd;
    logic              wordDone;
    logic              commitOk;
    logic              byteSel;
    logic              byteHi;
    logic [CODE_W-1:0] mode;
    logic [CODE_W-1:0] cycPtr;
  } rbCtl_t;

  typedef struct packed {
    logic [PAIR_W-1:0] pair;
    logic [WORD_W-1:0] d0;
    logic [WORD_W-1:0] d1;
  } stgEnt_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] data;
  } fifoEnt_t;
endpackage

// File: rtl/rb_ctrl.sv
`timescale 1ns/1ps
module rb_ctrl
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              byteMode,
  input  logic [CODE_W-1:0] modeSel,
  output rbCtl_t            ctl
);
  logic              rdAct, rdActQ, rdStart, rdEnd, wordDone;
  logic              byteHiQ;
  logic [CODE_W-1:0] modeQ, cycPtrQ;

  assign rdAct    = !csN && !rdN;
  assign rdStart  = rdAct && !rdActQ;
  assign rdEnd    = !rdAct && rdActQ;
  assign wordDone = rdEnd && (!byteMode || byteHiQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActQ  <= 1'b0;
      modeQ   <= '0;
      byteHiQ <= 1'b0;
      cycPtrQ <= '0;
    end else begin
      rdActQ <= rdAct;
      if (rdStart) modeQ <= modeSel;
      if (!byteMode)  byteHiQ <= 1'b0;
      else if (rdEnd) byteHiQ <= !byteHiQ;
      if (wordDone && modeQ == MODE_CYCLE)
        cycPtrQ <= (cycPtrQ == CODE_W'(NUM_CH - 1)) ? '0 : cycPtrQ + 1'b1;
    end
  end

  always_comb begin
    ctl.readActive = rdAct;
    ctl.readStart  = rdStart;
    ctl.readEnd    = rdEnd;
    ctl.wordDone   = wordDone;
    ctl.commitOk   = !rdAct && !rdEnd;
    ctl.byteSel    = byteMode;
    ctl.byteHi     = byteHiQ;
    ctl.mode       = rdStart ? modeSel : modeQ;
    ctl.cycPtr     = cycPtrQ;
  end

  // R7: latched code is frozen while the read continues
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdActQ && rdAct) |=> $stable(modeQ));
  // R2: rotation pointer stays on a real channel
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cycPtrQ < CODE_W'(NUM_CH));
  // R9: leaving byte mode returns to the low byte
  p_byte_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !byteMode |=> !byteHiQ);
endmodule

// File: rtl/rb_datapath.sv
`timescale 1ns/1ps
module rb_datapath
  import rb_pkg::*;
#(
  parameter int FIFO_DEPTH  = 18,
  parameter int STAGE_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbCtl_t            ctl,
  input  logic              wrStrobe,
  input  logic [PAIR_W-1:0] wrPair,
  input  logic [WORD_W-1:0] wrData0,
  input  logic [WORD_W-1:0] wrData1,
  input  logic              tagEn,
  output logic [WORD_W-1:0] rdData,
  output logic [CODE_W-1:0] rdTag
);
  localparam int STG_CNT_W = $clog2(STAGE_DEPTH + 1);
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

  // staging buffer for pairs
  stgEnt_t              stgQ [STAGE_DEPTH];
  logic [STG_CNT_W-1:0] stgCnt, stgAfter;
  logic                 commit, stgPush;
  stgEnt_t              head;

  assign commit   = ctl.commitOk && (stgCnt != '0);
  assign stgAfter = stgCnt - STG_CNT_W'(commit);
  assign stgPush  = wrStrobe && (wrPair < PAIR_W'(NUM_PAIRS)) &&
                    (stgAfter < STG_CNT_W'(STAGE_DEPTH));
  assign head     = stgQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgCnt <= '0;
      for (int i = 0; i < STAGE_DEPTH; i++) stgQ[i] <= '0;
    end else begin
      if (commit)
        for (int i = 0; i < STAGE_DEPTH - 1; i++) stgQ[i] <= stgQ[i+1];
      if (stgPush) stgQ[stgAfter] <= '{pair: wrPair, d0: wrData0, d1: wrData1};
      stgCnt <= stgAfter + STG_CNT_W'(stgPush);
    end
  end

  // latest result per channel
  logic [WORD_W-1:0] chanQ [NUM_CH];
  logic [CODE_W-1:0] code0, code1;
  assign code0 = {head.pair, 1'b0};
  assign code1 = {head.pair, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) chanQ[i] <= '0;
    end else if (commit) begin
      chanQ[code0] <= head.d0;
      chanQ[code1] <= head.d1;
    end
  end

  // shift-register queue
  fifoEnt_t         fifoQ   [FIFO_DEPTH];
  fifoEnt_t         fifoNxt [FIFO_DEPTH];
  logic [CNT_W-1:0] fifoCnt, cntNxt;
  logic             popHead;

  assign popHead = ctl.wordDone && (ctl.mode == MODE_FIFO) && (fifoCnt != '0);

  always_comb begin
    int drop;
    int base;
    fifoNxt = fifoQ;
    cntNxt  = fifoCnt;
    drop    = 0;
    base    = 0;
    if (popHead) begin
      for (int i = 0; i < FIFO_DEPTH - 1; i++) fifoNxt[i] = fifoQ[i+1];
      fifoNxt[FIFO_DEPTH-1] = '0;
      cntNxt = fifoCnt - 1'b1;
    end else if (commit) begin
      if (int'(fifoCnt) > FIFO_DEPTH - 2) drop = int'(fifoCnt) - (FIFO_DEPTH - 2);
      for (int i = 0; i < FIFO_DEPTH; i++)
        fifoNxt[i] = (i + drop < FIFO_DEPTH) ? fifoQ[i+drop] : '0;
      base = int'(fifoCnt) - drop;
      fifoNxt[base]   = '{code: code0, data: head.d0};
      fifoNxt[base+1] = '{code: code1, data: head.d1};
      cntNxt = CNT_W'(base + 2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoCnt <= '0;
      for (int i = 0; i < FIFO_DEPTH; i++) fifoQ[i] <= '0;
    end else begin
      fifoCnt <= cntNxt;
      fifoQ   <= fifoNxt;
    end
  end

  // read word selection and output register
  logic [WORD_W-1:0] selWord, outWord;
  logic [CODE_W-1:0] selCode;
  logic              selValid, tagOn;

  always_comb begin
    selValid = 1'b1;
    if (ctl.mode == MODE_CYCLE) begin
      selWord = chanQ[ctl.cycPtr];
      selCode = ctl.cycPtr;
    end else if (ctl.mode == MODE_FIFO) begin
      selValid = (fifoCnt != '0);
      selWord  = selValid ? fifoQ[0].data : '0;
      selCode  = fifoQ[0].code;
    end else begin
      selWord = chanQ[ctl.mode];
      selCode = ctl.mode;
    end
    if (!ctl.byteSel)   outWord = selWord;
    else if (ctl.byteHi) outWord = {{HALF_W{1'b0}}, selWord[WORD_W-1:HALF_W]};
    else                outWord = {{HALF_W{1'b0}}, selWord[HALF_W-1:0]};
    tagOn = tagEn && (ctl.mode[2:1] == 2'b11) && selValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdTag  <= '0;
    end else if (ctl.readStart) begin
      rdData <= outWord;
      rdTag  <= tagOn ? selCode : '0;
    end else if (ctl.readEnd) begin
      rdData <= '0;
      rdTag  <= '0;
    end
  end

  // R5: occupancy never exceeds capacity
  p_fifo_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_W'(FIFO_DEPTH));
  // R6: no store or removal lands while a read is active
  p_read_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readActive |=> $stable(fifoCnt));
  // R11: ending a read of an empty queue keeps it empty
  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readEnd && ctl.mode == MODE_FIFO && fifoCnt == '0) |=> (fifoCnt == '0));
  // R12: outputs return to zero once the read ends
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readEnd |=> (rdData == '0 && rdTag == '0));
endmodule

// File: rtl/sample_readout_bank.sv
`timescale 1ns/1ps
module sample_readout_bank
  import rb_pkg::*;
#(
  parameter int FIFO_PER_CH = 3,
  parameter int STAGE_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [PAIR_W-1:0] wrPair,
  input  logic [WORD_W-1:0] wrData0,
  input  logic [WORD_W-1:0] wrData1,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CODE_W-1:0] modeSel,
  input  logic              byteMode,
  input  logic              tagEn,
  output logic [WORD_W-1:0] rdData,
  output logic [CODE_W-1:0] rdTag
);
  localparam int FIFO_DEPTH = FIFO_PER_CH * NUM_CH;

  rbCtl_t ctl;

  rb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rdN      (rdN),
    .byteMode (byteMode),
    .modeSel  (modeSel),
    .ctl      (ctl)
  );

  rb_datapath #(
    .FIFO_DEPTH  (FIFO_DEPTH),
    .STAGE_DEPTH (STAGE_DEPTH)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrStrobe (wrStrobe),
    .wrPair   (wrPair),
    .wrData0  (wrData0),
    .wrData1  (wrData1),
    .tagEn    (tagEn),
    .rdData   (rdData),
    .rdTag    (rdTag)
  );
endmodule

// File: tb/sample_readout_bank_bench.sv
`timescale 1ns/1ps
module sample_readout_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [1:0]  wrPair = '0;
  logic [15:0] wrData0 = '0, wrData1 = '0;
  logic        csN = 1'b1, rdN = 1'b1;
  logic [2:0]  modeSel = '0;
  logic        byteMode = 1'b0, tagEn = 1'b0;
  logic [15:0] rdData;
  logic [2:0]  rdTag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sample_readout_bank u_sample_readout_bank (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrPair(wrPair),
    .wrData0(wrData0), .wrData1(wrData1), .csN(csN), .rdN(rdN),
    .modeSel(modeSel), .byteMode(byteMode), .tagEn(tagEn),
    .rdData(rdData), .rdTag(rdTag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; csN = 1'b1; rdN = 1'b1; wrStrobe = 1'b0; byteMode = 1'b0; tagEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] p, input logic [15:0] d0, input logic [15:0] d1);
    @(negedge clk);
    wrStrobe = 1'b1; wrPair = p; wrData0 = d0; wrData1 = d1;
    @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [2:0] m, output logic [15:0] d, output logic [2:0] t);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; modeSel = m;
    @(negedge clk);
    d = rdData; t = rdTag;
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] d; logic [2:0] t;
    doReset();
    chk("R12 idle data zero", rdData, 16'h0);
    doRead(3'd0, d, t);
    chk("R8 channel cleared", d, 16'h0);
    tagEn = 1'b1;
    doRead(3'd7, d, t);
    chk("R11 empty queue data", d, 16'h0);
    chk("R11 empty queue tag", {13'b0, t}, 16'h0);
  endtask

  task automatic testDirect();
    logic [15:0] d; logic [2:0] t;
    doReset();
    doWrite(2'd0, 16'h1111, 16'h2222);
    doWrite(2'd1, 16'h3333, 16'h4444);
    doWrite(2'd2, 16'h5555, 16'h6666);
    doWrite(2'd1, 16'h7777, 16'h8888);
    tagEn = 1'b1;
    for (int c = 0; c < 6; c++) begin
      logic [15:0] e;
      case (c)
        0: e = 16'h1111; 1: e = 16'h2222; 2: e = 16'h7777;
        3: e = 16'h8888; 4: e = 16'h5555; default: e = 16'h6666;
      endcase
      doRead(3'(c), d, t);
      chk("R1 direct channel data", d, e);
      chk("R1 direct tag zero", {13'b0, t}, 16'h0);
    end
    chk("R12 zero after read", rdData, 16'h0);
  endtask

  task automatic testCycle();
    logic [15:0] d; logic [2:0] t;
    doReset();
    doWrite(2'd0, 16'hA000, 16'hA001);
    doWrite(2'd1, 16'hB000, 16'hB001);
    doWrite(2'd2, 16'hC000, 16'hC001);
    tagEn = 1'b1;
    for (int k = 0; k < 8; k++) begin
      int c;
      c = k % 6;
      doRead(3'd6, d, t);
      chk(k == 0 ? "R3 cycle starts at A0" : "R2 cycle order", d,
          {4'hA + 4'(c / 2), 11'h0, 1'(c % 2)});
      chk("R10 cycle tag", {13'b0, t}, 16'(c));
    end
    tagEn = 1'b0;
    doRead(3'd6, d, t);
    chk("R10 tag off", {13'b0, t}, 16'h0);
  endtask

  task automatic testFifoOrder();
    logic [15:0] d; logic [2:0] t;
    doReset();
    doWrite(2'd2, 16'h00C0, 16'h00C1);
    doWrite(2'd0, 16'h00A0, 16'h00A1);
    tagEn = 1'b1;
    doRead(3'd7, d, t); chk("R4 queue first", d, 16'h00C0); chk("R10 queue tag", {13'b0, t}, 16'd4);
    doRead(3'd7, d, t); chk("R4 queue second", d, 16'h00C1); chk("R10 queue tag", {13'b0, t}, 16'd5);
    doRead(3'd7, d, t); chk("R4 queue third", d, 16'h00A0); chk("R10 queue tag", {13'b0, t}, 16'd0);
    doRead(3'd7, d, t); chk("R4 queue fourth", d, 16'h00A1);
    doRead(3'd7, d, t); chk("R11 empty read", d, 16'h0);
    doWrite(2'd1, 16'h00B0, 16'h00B1);
    doRead(3'd7, d, t); chk("R11 queue intact after empty read", d, 16'h00B0);
  endtask

  task automatic testOverflow();
    logic [15:0] d; logic [2:0] t;
    doReset();
    for (int k = 0; k < 10; k++)
      doWrite(2'(k % 3), 16'h0100 + 16'(2*k), 16'h0100 + 16'(2*k + 1));
    for (int j = 0; j < 18; j++) begin
      doRead(3'd7, d, t);
      chk("R5 overflow drops oldest", d, 16'h0102 + 16'(j));
    end
    doRead(3'd7, d, t);
    chk("R5 capacity 18", d, 16'h0);
  endtask

  task automatic testDefer();
    logic [15:0] d; logic [2:0] t;
    doReset();
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; modeSel = 3'd7;
    @(negedge clk);
    chk("R12 empty read data", rdData, 16'h0);
    wrStrobe = 1'b1; wrPair = 2'd0; wrData0 = 16'hD0D0; wrData1 = 16'hD1D1;
    @(negedge clk);
    wrStrobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 data held during read", rdData, 16'h0);
    csN = 1'b1; rdN = 1'b1;
    repeat (2) @(negedge clk);
    doRead(3'd7, d, t); chk("R6 deferred x0 kept", d, 16'hD0D0);
    doRead(3'd7, d, t); chk("R6 deferred x1 kept", d, 16'hD1D1);
    doRead(3'd0, d, t); chk("R6 channel updated after read", d, 16'hD0D0);
  endtask

  task automatic testLatch();
    logic [15:0] d; logic [2:0] t;
    doReset();
    doWrite(2'd0, 16'h0A0A, 16'h1A1A);
    @(negedge clk); rdN = 1'b0; csN = 1'b1; modeSel = 3'd5;
    @(negedge clk); modeSel = 3'd0;
    @(negedge clk); csN = 1'b0;
    @(negedge clk); modeSel = 3'd7;
    @(negedge clk);
    chk("R7 code taken at later fall", rdData, 16'h0A0A);
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk);
    doRead(3'd7, d, t);
    chk("R7 no pop from direct read", d, 16'h0A0A);
  endtask

  task automatic testByte();
    logic [15:0] d; logic [2:0] t;
    doReset();
    doWrite(2'd0, 16'hABCD, 16'h1234);
    doWrite(2'd1, 16'h5678, 16'h9A00);
    @(negedge clk); byteMode = 1'b1;
    doRead(3'd7, d, t); chk("R9 queue low byte", d, 16'h00CD);
    doRead(3'd7, d, t); chk("R9 queue high byte", d, 16'h00AB);
    doRead(3'd7, d, t); chk("R9 pop after high byte", d, 16'h0034);
    doRead(3'd7, d, t); chk("R9 queue high byte", d, 16'h0012);
    doRead(3'd6, d, t); chk("R9 cycle low byte", d, 16'h00CD);
    doRead(3'd6, d, t); chk("R9 cycle high byte", d, 16'h00AB);
    doRead(3'd6, d, t); chk("R9 cycle step after word", d, 16'h0034);
  endtask

  initial begin
    testReset();
    testDirect();
    testCycle();
    testFifoOrder();
    testOverflow();
    testDefer();
    testLatch();
    testByte();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule